// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers interrupt request lines from a set of numbered sources and routes them to a small number of target contexts, such as the privilege levels of one or more processor cores. Each source has a programmable priority. Each context has its own enable bit per source and its own priority threshold. A per-source gateway turns the raw request line into a single pending request. The gateway follows either the level of the line or its rising edge, chosen per source by a parameter bit. A source then stays blocked until software signals that it has finished servicing it.

Each context has one interrupt output. Software reads a per-context claim register to take the best pending source. It writes the same ID back to that register when service is done. All registers sit on a simple 32-bit word bus. A read's data appears on the cycle after the read strobe and is held until the next read. When the write and read strobes are both high in the same cycle, the write takes effect and the read does not. Source ID 0 is reserved and never signals.

Top module: `irq_router`

## Requirements
- R1: The priority of source n is the word at byte address 4*n. Only the low PRIO_W bits are stored, and the upper read bits are zero. The word at address 0, for source 0, always reads 0 and ignores writes.
- R2: The enable word k of context c is at byte address 0x2000 + 0x80*c + 4*k. Bit b of that word enables source 32*k + b. The bit for source 0 always reads 0.
- R3: The threshold of context c is at byte address 0x200000 + 0x1000*c. Its claim/complete register is at that address + 4.
- R4: A source is eligible for context c only when it is pending, enabled in c, and its priority is strictly greater than the threshold of c. A source of priority 0 is therefore never eligible.
- R5: A claim read returns the eligible source with the highest priority, with ties going to the lowest ID, and clears that source's pending state.
- R6: A claim read with no eligible source returns 0 and changes no state.
- R7: A level-mode source, once forwarded, raises no new request until its ID is completed. If its line is still high at completion, it becomes pending again at once.
- R8: An edge-mode source becomes pending on a rising edge of its line. While it is blocked, it remembers at most one further edge and forwards that edge on completion. A line held high raises only one request.
- R9: A completion write is ignored when the written value is not a valid source ID, or when the ID is not enabled in the context whose register is written. A completion that is accepted later still unblocks the source.
- R10: Each context output is registered. It reflects eligibility one cycle after a change of priority, enable, threshold, pending state or claim.
- R11: Reset clears all priorities, enables, thresholds, pending states, blocked flags and context outputs.
- R12: A threshold equal to the largest priority value keeps that context's output low and its claims at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqSrc | input | NUM_SRC | Request lines, bit n for source n (bit 0 unused) |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| ctxIrq | output | NUM_CTX | Interrupt output per context |

## Verification
Arbitration is tried with several sources at equal and at unequal priorities. This separates a correct highest-priority, lowest-ID pick from an order based only on ID. Thresholds are set just at and just below a source's priority, which catches a non-strict comparison. Level and edge lines are each held high through claim and completion, and edge lines are also pulsed repeatedly while blocked. These patterns distinguish re-arming on completion, single-edge memory and edge collapsing. Completions are sent from the wrong context and with an ID that aliases a valid source in its low bits, to show that both filters act at the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IdxW = 10;
  localparam int CtxW = 4;

  typedef enum logic [2:0] {
    RegNone,
    RegPrio,
    RegEnable,
    RegThresh,
    RegClaim
  } regKind_e;

  typedef struct packed {
    logic            wr;
    logic            rd;
    regKind_e        kind;
    logic [IdxW-1:0] idx;
    logic [CtxW-1:0] ctx;
    logic [31:0]     wdata;
  } regStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output regStrobe_t        strobe
);
  localparam int NumWords = (NUM_SRC + 31) / 32;
  localparam logic [ADDR_W-1:0] EnBase  = ADDR_W'('h2000);
  localparam logic [ADDR_W-1:0] CtlBase = ADDR_W'('h200000);

  logic [ADDR_W-1:0] enCtx;
  logic [ADDR_W-1:0] ctlCtx;
  logic [ADDR_W-1:0] srcIdx;
  logic              aligned;

  always_comb begin
    enCtx   = (busAddr - EnBase) >> 7;
    ctlCtx  = (busAddr - CtlBase) >> 12;
    srcIdx  = busAddr >> 2;
    aligned = (busAddr[1:0] == 2'b00);

    strobe       = '0;
    strobe.kind  = RegNone;
    strobe.wr    = busWe;
    strobe.rd    = busRe & ~busWe;
    strobe.wdata = busWdata;

    if (aligned) begin
      if (busAddr < EnBase) begin
        if (srcIdx < ADDR_W'(NUM_SRC)) begin
          strobe.kind = RegPrio;
          strobe.idx  = IdxW'(srcIdx);
        end
      end else if (busAddr < CtlBase) begin
        if (enCtx < ADDR_W'(NUM_CTX) && ADDR_W'(busAddr[6:2]) < ADDR_W'(NumWords)) begin
          strobe.kind = RegEnable;
          strobe.idx  = IdxW'(busAddr[6:2]);
          strobe.ctx  = CtxW'(enCtx);
        end
      end else if (ctlCtx < ADDR_W'(NUM_CTX)) begin
        strobe.ctx = CtxW'(ctlCtx);
        if (busAddr[11:0] == 12'h000) begin
          strobe.kind = RegThresh;
        end else if (busAddr[11:0] == 12'h004) begin
          strobe.kind = RegClaim;
        end
      end
    end
  end
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqIn,
  input  logic claimHit,
  input  logic complHit,
  output logic pend
);
  logic busy;
  logic busyNext;
  logic want;
  logic fire;

  assign busyNext = busy & ~complHit;
  assign fire     = want & ~busyNext;

  if (EDGE) begin : g_edge
    logic prevIn;
    logic heldEdge;
    logic rise;

    assign rise = reqIn & ~prevIn;
    assign want = rise | heldEdge;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevIn   <= 1'b0;
        heldEdge <= 1'b0;
      end else begin
        prevIn <= reqIn;
        if (fire) begin
          heldEdge <= 1'b0;
        end else if (busyNext && rise) begin
          heldEdge <= 1'b1;
        end
      end
    end
  end else begin : g_level
    assign want = reqIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      busy <= fire | busyNext;
      if (fire) begin
        pend <= 1'b1;
      end else if (claimHit) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobe_t                     strobe,
  input  logic [NUM_SRC-1:0]             srcReq,
  output logic [31:0]                    rdData,
  output logic [NUM_CTX-1:0]             ctxIrq,
  output logic [NUM_CTX-1:0][PRIO_W-1:0] thrOut
);
  localparam int IdW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] enable;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] elig;
  logic [NUM_CTX-1:0][IdW-1:0]     bestId;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  bestPrio;
  logic [NUM_SRC-1:0]              pend;
  logic [NUM_SRC-1:0]              claimHit;
  logic [NUM_SRC-1:0]              complHit;
  logic [IdW-1:0]                  selBest;
  logic [NUM_SRC-1:0]              selEn;
  logic [PRIO_W-1:0]               selThr;
  logic                            isClaimRd;
  logic                            isComplWr;
  logic [31:0]                     rdNext;

  assign thrOut = thr;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gw
    irq_gateway #(.EDGE(EDGE_MASK[s])) i_gw (
      .clk      (clk),
      .rstN     (rstN),
      .reqIn    (srcReq[s]),
      .claimHit (claimHit[s]),
      .complHit (complHit[s]),
      .pend     (pend[s])
    );
  end

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prio   <= '0;
      enable <= '0;
      thr    <= '0;
    end else if (strobe.wr) begin
      case (strobe.kind)
        RegPrio: begin
          for (int s = 1; s < NUM_SRC; s++) begin
            if (strobe.idx == IdxW'(s)) prio[s] <= strobe.wdata[PRIO_W-1:0];
          end
        end
        RegEnable: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            for (int s = 1; s < NUM_SRC; s++) begin
              if (strobe.ctx == CtxW'(c) && strobe.idx == IdxW'(s / 32)) begin
                enable[c][s] <= strobe.wdata[s % 32];
              end
            end
          end
        end
        RegThresh: begin
          for (int c = 0; c < NUM_CTX; c++) begin
            if (strobe.ctx == CtxW'(c)) thr[c] <= strobe.wdata[PRIO_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // eligibility and per-context arbitration
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      bestPrio[c] = '0;
      bestId[c]   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        elig[c][s] = pend[s] & enable[c][s] & (prio[s] > thr[c]);
        if (elig[c][s] && prio[s] > bestPrio[c]) begin
          bestPrio[c] = prio[s];
          bestId[c]   = IdW'(s);
        end
      end
    end
  end

  // context selection, claim and completion routing
  always_comb begin
    selBest = '0;
    selEn   = '0;
    selThr  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (strobe.ctx == CtxW'(c)) begin
        selBest = bestId[c];
        selEn   = enable[c];
        selThr  = thr[c];
      end
    end
    isClaimRd = strobe.rd && strobe.kind == RegClaim;
    isComplWr = strobe.wr && strobe.kind == RegClaim;
    claimHit  = '0;
    complHit  = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (isClaimRd && selBest == IdW'(s)) claimHit[s] = 1'b1;
      if (isComplWr && strobe.wdata == 32'(s) && selEn[s]) complHit[s] = 1'b1;
    end
  end

  always_comb begin
    rdNext = '0;
    case (strobe.kind)
      RegPrio: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (strobe.idx == IdxW'(s)) rdNext = 32'(prio[s]);
        end
      end
      RegEnable: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (strobe.idx == IdxW'(s / 32)) rdNext[s % 32] = selEn[s];
        end
      end
      RegThresh: rdNext = 32'(selThr);
      RegClaim:  rdNext = 32'(selBest);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      ctxIrq <= '0;
    end else begin
      if (strobe.rd) rdData <= rdNext;
      for (int c = 0; c < NUM_CTX; c++) begin
        ctxIrq[c] <= |elig[c];
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = {4'hF, {(NUM_SRC - 4){1'b0}}}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CTX-1:0] ctxIrq
);
  localparam int ThrBits = NUM_CTX * PRIO_W;

  regStrobe_t                     strobe;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thrView;
  logic [ThrBits-1:0]             thrFlat;

  assign thrFlat = thrView;

  irq_ctrl #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
  ) i_ctrl (
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  irq_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CTX   (NUM_CTX),
    .PRIO_W    (PRIO_W),
    .EDGE_MASK (EDGE_MASK)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .srcReq (irqSrc),
    .rdData (busRdata),
    .ctxIrq (ctxIrq),
    .thrOut (thrView)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWe,
  input logic                      busRe,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [31:0]               busRdata,
  input logic [NUM_CTX-1:0]        ctxIrq,
  input logic [NUM_CTX*PRIO_W-1:0] thrFlat
);
  localparam logic [ADDR_W-1:0] CtlBase = ADDR_W'('h200000);

  logic claimRd;
  assign claimRd = busRe && !busWe && busAddr >= CtlBase && busAddr[11:0] == 12'h004 &&
                   ((busAddr - CtlBase) >> 12) < ADDR_W'(NUM_CTX);

  AST_ID0_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && busAddr == '0) |=> (busRdata == '0)) else $error("id0 priority"); // R1

  AST_CLAIM_ID_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    claimRd |=> (busRdata < 32'(NUM_SRC))) else $error("claim id range"); // R5

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (ctxIrq == '0)) else $error("output after reset"); // R11

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    AST_THR_MAX_MUTE: assert property (@(posedge clk) disable iff (!rstN)
      $past(thrFlat[c*PRIO_W +: PRIO_W] == {PRIO_W{1'b1}}) |-> !ctxIrq[c]) else $error("muted ctx"); // R12
  end
endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CTX (NUM_CTX),
  .PRIO_W  (PRIO_W),
  .ADDR_W  (ADDR_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busRe    (busRe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .ctxIrq   (ctxIrq),
  .thrFlat  (thrFlat)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int NUM_SRC = 32;
  localparam int NUM_CTX = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] irqSrc = '0;
  logic               busWe = 1'b0;
  logic               busRe = 1'b0;
  logic [23:0]        busAddr = '0;
  logic [31:0]        busWdata = '0;
  logic [31:0]        busRdata;
  logic [NUM_CTX-1:0] ctxIrq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk      (clk),
    .rstN     (rstN),
    .irqSrc   (irqSrc),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .ctxIrq   (ctxIrq)
  );

  function automatic logic [23:0] prioA(int id);  return 24'(id * 4); endfunction
  function automatic logic [23:0] enA(int c);     return 24'('h2000 + c * 'h80); endfunction
  function automatic logic [23:0] thrA(int c);    return 24'('h200000 + c * 'h1000); endfunction
  function automatic logic [23:0] clmA(int c);    return 24'('h200004 + c * 'h1000); endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input int id);
    @(negedge clk); irqSrc[id] = 1'b1;
    @(negedge clk); irqSrc[id] = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R11", "outputs after reset", 32'(ctxIrq), 32'h0);
    rd(prioA(5), d);  chk("R11", "priority 5 after reset", d, 0);
    rd(enA(0), d);    chk("R11", "enable ctx0 after reset", d, 0);
    rd(thrA(1), d);   chk("R11", "threshold ctx1 after reset", d, 0);
    rd(clmA(0), d);   chk("R11", "claim ctx0 after reset", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    wr(prioA(5), 32'hFF); rd(prioA(5), d); chk("R1", "priority truncated", d, 7);
    wr(prioA(0), 32'h5);  rd(prioA(0), d); chk("R1", "source 0 priority", d, 0);
    wr(enA(0), 32'hFFFF_FFFF); rd(enA(0), d); chk("R2", "enable word ctx0", d, 32'hFFFF_FFFE);
    wr(enA(1), 32'h0000_0F00); rd(enA(1), d); chk("R2", "enable word ctx1", d, 32'h0000_0F00);
    rd(enA(0), d); chk("R2", "ctx0 untouched by ctx1", d, 32'hFFFF_FFFE);
    wr(thrA(1), 32'h3); rd(thrA(1), d); chk("R3", "threshold ctx1", d, 3);
    rd(thrA(0), d); chk("R3", "threshold ctx0", d, 0);
    wr(enA(0), 0); wr(enA(1), 0); wr(thrA(1), 0); wr(prioA(5), 0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    wr(prioA(3), 2); wr(enA(0), 32'h1 << 3); wr(thrA(0), 2);
    irqSrc[3] = 1'b1;
    waitCyc(2);
    chk("R4", "priority equal to threshold", 32'(ctxIrq[0]), 0);
    wr(thrA(0), 1);
    chk("R10", "output not yet updated", 32'(ctxIrq[0]), 0);
    waitCyc(1);
    chk("R10", "output one cycle after threshold", 32'(ctxIrq[0]), 1);
    chk("R4", "ctx1 not enabled", 32'(ctxIrq[1]), 0);
    rd(clmA(0), d); chk("R5", "claim level source", d, 3);
    waitCyc(1);
    chk("R5", "output drops after claim", 32'(ctxIrq[0]), 0);
    rd(clmA(0), d); chk("R7", "blocked while line high", d, 0);
    wr(clmA(0), 3);
    waitCyc(1);
    chk("R7", "re-pends on completion", 32'(ctxIrq[0]), 1);
    rd(clmA(0), d); chk("R7", "second claim", d, 3);
    irqSrc[3] = 1'b0;
    wr(clmA(0), 3);
    waitCyc(2);
    chk("R7", "no request after line low", 32'(ctxIrq[0]), 0);
    rd(clmA(0), d); chk("R7", "claim empty", d, 0);
    wr(enA(0), 0); wr(thrA(0), 0);
  endtask

  task automatic testArb();
    logic [31:0] d;
    wr(prioA(6), 4); wr(prioA(9), 6); wr(prioA(12), 6); wr(prioA(4), 0);
    wr(enA(0), (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 9) | (32'h1 << 12));
    irqSrc[4] = 1'b1; irqSrc[6] = 1'b1; irqSrc[9] = 1'b1; irqSrc[12] = 1'b1;
    waitCyc(2);
    rd(clmA(0), d); chk("R5", "highest priority lowest id", d, 9);
    rd(clmA(0), d); chk("R5", "tie partner", d, 12);
    rd(clmA(0), d); chk("R5", "lower priority", d, 6);
    rd(clmA(0), d); chk("R4", "priority 0 never claimed", d, 0);
    waitCyc(1);
    chk("R4", "priority 0 no output", 32'(ctxIrq[0]), 0);
    irqSrc[4] = 1'b0; irqSrc[6] = 1'b0; irqSrc[9] = 1'b0; irqSrc[12] = 1'b0;
    wr(clmA(0), 9); wr(clmA(0), 12); wr(clmA(0), 6);
    wr(enA(0), 0);
  endtask

  task automatic testEmpty();
    logic [31:0] d;
    wr(prioA(7), 3); wr(enA(1), 32'h1 << 7);
    irqSrc[7] = 1'b1;
    waitCyc(2);
    rd(clmA(0), d); chk("R6", "empty claim returns 0", d, 0);
    waitCyc(1);
    chk("R6", "other context unaffected", 32'(ctxIrq[1]), 1);
    rd(clmA(1), d); chk("R6", "pending kept", d, 7);
    irqSrc[7] = 1'b0;
    wr(clmA(1), 7); wr(enA(1), 0);
  endtask

  task automatic testEdge();
    logic [31:0] d;
    wr(prioA(29), 5); wr(enA(0), 32'h1 << 29);
    pulse(29);
    waitCyc(1);
    chk("R8", "edge raises output", 32'(ctxIrq[0]), 1);
    rd(clmA(0), d); chk("R8", "claim edge source", d, 29);
    pulse(29); pulse(29);
    rd(clmA(0), d); chk("R8", "blocked while busy", d, 0);
    wr(clmA(0), 29);
    rd(clmA(0), d); chk("R8", "remembered edge", d, 29);
    wr(clmA(0), 29);
    rd(clmA(0), d); chk("R8", "only one edge remembered", d, 0);
    wr(prioA(30), 5); wr(enA(0), 32'h1 << 30);
    irqSrc[30] = 1'b1;
    waitCyc(2);
    rd(clmA(0), d); chk("R8", "held line claim", d, 30);
    wr(clmA(0), 30);
    rd(clmA(0), d); chk("R8", "held line single request", d, 0);
    irqSrc[30] = 1'b0;
    wr(enA(0), 0);
  endtask

  task automatic testComplFilter();
    logic [31:0] d;
    wr(prioA(10), 2); wr(enA(0), 32'h1 << 10);
    irqSrc[10] = 1'b1;
    waitCyc(2);
    rd(clmA(0), d); chk("R9", "claim source 10", d, 10);
    wr(clmA(1), 10);
    waitCyc(1);
    chk("R9", "completion from non-enabled ctx ignored", 32'(ctxIrq[0]), 0);
    wr(clmA(0), 42);
    waitCyc(1);
    chk("R9", "out-of-range completion ignored", 32'(ctxIrq[0]), 0);
    rd(clmA(0), d); chk("R9", "still blocked", d, 0);
    wr(enA(1), 32'h1 << 10);
    wr(clmA(1), 10);
    waitCyc(1);
    chk("R9", "later completion accepted", 32'(ctxIrq[0]), 1);
    rd(clmA(0), d); chk("R9", "re-claim after completion", d, 10);
    irqSrc[10] = 1'b0;
    wr(clmA(0), 10);
    wr(enA(0), 0); wr(enA(1), 0);
  endtask

  task automatic testMute();
    logic [31:0] d;
    wr(prioA(11), 7); wr(enA(1), 32'h1 << 11); wr(thrA(1), 7);
    irqSrc[11] = 1'b1;
    waitCyc(2);
    chk("R12", "max threshold mutes", 32'(ctxIrq[1]), 0);
    rd(clmA(1), d); chk("R12", "muted claim", d, 0);
    wr(thrA(1), 6);
    waitCyc(1);
    chk("R12", "unmuted", 32'(ctxIrq[1]), 1);
    rd(clmA(1), d); chk("R12", "claim after unmute", d, 11);
    irqSrc[11] = 1'b0;
    wr(clmA(1), 11); wr(thrA(1), 0); wr(enA(1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testRegs();
    testLevel();
    testArb();
    testEmpty();
    testEdge();
    testComplFilter();
    testMute();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule